// File: doc/BRIEF.md
# Grouped-Carry Loadable Up/Down Counter

This block is a synchronous binary counter that can count in either direction, take a parallel value, and stop when its enable is low. The count is not produced by one adder. It is split into two-bit slices. Each slice works out its own carry (when counting up) or borrow (when counting down) from three inputs: the enable arriving from the slice below, the direction, and its own two bits. That signal enables the slice above. A second, internal term toggles the upper bit of the pair. The lowest slice takes its incoming enable straight from the count-enable input.

With default parameters there are twelve slices, which gives a 24-bit count. The carry leaving the top slice is brought out as a terminal-count flag, so that several counters can be cascaded or a wrap can be detected. All controls are active-high except the reset. The reset is synchronous and active-low.

Top module: `grp_updn_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the count becomes 0 after that edge. Reset takes priority over load and counting.
- R2: With `rst_n` high, `ld` low and `ce` low, the count keeps its value across the edge, whatever `up` is.
- R3: With `rst_n` high, `ld` low, `ce` high and `up` = 1, the count rises by one at the edge. 0xFFFFFF is followed by 0x000000.
- R4: With `rst_n` high, `ld` low, `ce` high and `up` = 0, the count falls by one at the edge. 0x000000 is followed by 0xFFFFFF.
- R5: With `rst_n` high and `ld` high, the count takes `ld_val` at the edge, whatever `ce` and `up` are.
- R6: `tc_out` is combinational. It is 1 exactly when `ce` is 1 and either `up` = 1 with the count at 0xFFFFFF, or `up` = 0 with the count at 0x000000. It does not depend on `ld`.
- R7: Carries and borrows pass correctly across every two-bit slice boundary. For example, 0x00FFFF counting up gives 0x010000, and 0x010000 counting down gives 0x00FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active-low |
| ce | input | 1 | Count enable; the incoming carry of the lowest slice |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| ld | input | 1 | Parallel load strobe |
| ld_val | input | 24 | Value captured on load |
| q | output | 24 | Present count |
| tc_out | output | 1 | Carry or borrow out of the top slice |

## Verification
Load and counting can both be requested in the same cycle: `ld` and `ce` are high together. At the terminal count, the terminal-count flag can also be high in a cycle where a load replaces the wrap. The bench raises `ld` and `ce` together, both at random and by direct stimulus at 0xFFFFFF and 0x000000. It expects the loaded value to win while `tc_out` stays high for that cycle. A behavioural reference is compared with the count on every clock, and a cycle where reset and load coincide is also driven.

// File: rtl/grp_cnt_pkg.sv
// Package: shared constants and types for the grouped-carry counter.
// Assumes every slice holds exactly two bits.
package grp_cnt_pkg;
    localparam int SLICE_W = 2;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/grp_slice_carry.sv
// Module: grp_slice_carry
// Purely combinational carry logic for one two-bit slice. From the incoming
// enable, the direction and the slice's present bits it produces the toggle
// enables for both bits and the carry/borrow passed to the next slice.
// Assumes cin is already gated by everything below this slice.
module grp_slice_carry
    import grp_cnt_pkg::*;
(
    input  logic               cin,
    input  dir_e               dir,
    input  logic [SLICE_W-1:0] bits,
    output logic [SLICE_W-1:0] tgl,
    output logic               cout
);
    logic lo_ok;
    logic hi_ok;

    // Decide whether each bit is at its direction's terminal value.
    always_comb begin
        lo_ok = (dir == DIR_UP) ? bits[0] : ~bits[0];
        hi_ok = (dir == DIR_UP) ? bits[1] : ~bits[1];
    end

    // Build the toggle enables and the outgoing carry.
    always_comb begin
        tgl[0] = cin;
        tgl[1] = cin & lo_ok;
        cout   = cin & lo_ok & hi_ok;
    end
endmodule

// File: rtl/grp_slice.sv
// Module: grp_slice
// One two-bit slice of the counter: its register pair plus its carry cell.
// Priority at the clock edge: synchronous reset, then load, then toggle.
// Assumes rst_n is synchronous to clk.
module grp_slice
    import grp_cnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cin,
    input  dir_e               dir,
    input  logic               ld,
    input  logic [SLICE_W-1:0] ld_bits,
    output logic [SLICE_W-1:0] bits,
    output logic               cout
);
    logic [SLICE_W-1:0] tgl;

    grp_slice_carry u_carry (
        .cin  (cin),
        .dir  (dir),
        .bits (bits),
        .tgl  (tgl),
        .cout (cout)
    );

    // Hold the slice's two count bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else if (ld) begin
            bits <= ld_bits;
        end else begin
            bits <= bits ^ tgl;
        end
    end
endmodule

// File: rtl/grp_updn_counter.sv
// Module: grp_updn_counter
// Loadable up/down counter made of N_SLICES two-bit slices. The slices are
// chained through explicit carry/borrow signals. The carry from the top
// slice is brought out as tc_out.
// Assumes rst_n is synchronous and active-low, and that all other controls
// are active-high.
module grp_updn_counter
    import grp_cnt_pkg::*;
#(
    parameter int N_SLICES = 12,
    localparam int WIDTH   = N_SLICES * SLICE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             up,
    input  logic             ld,
    input  logic [WIDTH-1:0] ld_val,
    output logic [WIDTH-1:0] q,
    output logic             tc_out
);
    logic [N_SLICES:0] chain;
    dir_e              dir;

    // Map the direction pin onto the shared enum.
    always_comb begin
        dir      = dir_e'(up);
        chain[0] = ce;
    end

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        grp_slice u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .cin     (chain[s]),
            .dir     (dir),
            .ld      (ld),
            .ld_bits (ld_val[s*SLICE_W +: SLICE_W]),
            .bits    (q[s*SLICE_W +: SLICE_W]),
            .cout    (chain[s+1])
        );
    end

    // Expose the carry leaving the top slice.
    always_comb tc_out = chain[N_SLICES];
endmodule

// File: rtl/grp_updn_counter_chk.sv
// Module: grp_updn_counter_chk
// Checker bound to grp_updn_counter. It relates the count before and after
// each edge to the controls, and the top carry to the count.
module grp_updn_counter_chk #(
    parameter int WIDTH = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             up,
    input logic             ld,
    input logic [WIDTH-1:0] ld_val,
    input logic [WIDTH-1:0] q,
    input logic             tc_out
);
    // R1: reset clears the count.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    // R2: no enable and no load means hold.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !ce) |=> $stable(q));

    // R3: count up by one, modulo 2^WIDTH.
    a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && ce && up) |=> q == WIDTH'($past(q) + 1'b1));

    // R4: count down by one, modulo 2^WIDTH.
    a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && ce && !up) |=> q == WIDTH'($past(q) - 1'b1));

    // R5: load captures the value.
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> q == $past(ld_val));

    // R6: terminal carry only at the terminal count with enable.
    a_r6_tc_needs_ce: assert property (@(posedge clk) disable iff (!rst_n)
        tc_out |-> ce && (up ? (&q) : (~|q)));
endmodule

bind grp_updn_counter grp_updn_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (ce),
    .up     (up),
    .ld     (ld),
    .ld_val (ld_val),
    .q      (q),
    .tc_out (tc_out)
);

// File: tb/grp_updn_counter_bench.sv
// Bench: a behavioural reference count compared with the counter each cycle.
module grp_updn_counter_bench;
    localparam int CLK_P = 10;
    localparam int W     = 24;

    logic         clk = 1'b0;
    logic         rst_n, ce, up, ld;
    logic [W-1:0] ld_val, q;
    logic         tc_out;

    logic [W-1:0] ref_q = '0;
    int           n_chk = 0;
    int           n_bad = 0;

    grp_updn_counter u_grp_updn_counter (
        .clk (clk), .rst_n (rst_n), .ce (ce), .up (up), .ld (ld),
        .ld_val (ld_val), .q (q), .tc_out (tc_out)
    );

    always #(CLK_P/2) clk = ~clk;

    // Ends a hung run as a failure.
    initial begin
        #(CLK_P * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check tc, clock, check count.
    task automatic step(input logic rn, input logic c, input logic u,
                        input logic l, input logic [W-1:0] d, input string tag);
        logic exp_tc;
        string req;
        @(negedge clk);
        rst_n = rn; ce = c; up = u; ld = l; ld_val = d;
        #1;
        if (rn) begin
            exp_tc = c && (u ? (ref_q == {W{1'b1}}) : (ref_q == '0));
            chk({"R6 ", tag}, W'(tc_out), W'(exp_tc));
        end
        if (!rn)      begin ref_q = '0;       req = "R1"; end
        else if (l)   begin ref_q = d;        req = "R5"; end
        else if (!c)  begin                   req = "R2"; end
        else if (u)   begin ref_q = ref_q + 1'b1; req = "R3"; end
        else          begin ref_q = ref_q - 1'b1; req = "R4"; end
        @(posedge clk);
        #1;
        chk({req, " ", tag}, q, ref_q);
    endtask

    initial begin
        rst_n = 1'b0; ce = 1'b0; up = 1'b1; ld = 1'b0; ld_val = '0;
        step(0, 1, 1, 1, 24'h123456, "reset with load");   // R1
        chk("R1 reset state", q, '0);
        step(1, 0, 1, 0, '0, "hold at zero");              // R2
        step(1, 1, 0, 0, '0, "wrap down from zero");       // R4
        chk("R4 wrap result", q, 24'hFFFFFF);
        step(1, 1, 1, 0, '0, "wrap up from all ones");     // R3
        chk("R3 wrap result", q, 24'h000000);
        step(1, 0, 0, 1, 24'h00FFFF, "load with ce low");  // R5
        step(1, 1, 1, 0, '0, "ripple up");                 // R7
        chk("R7 ripple up", q, 24'h010000);
        step(1, 1, 0, 0, '0, "ripple down");               // R7
        chk("R7 ripple down", q, 24'h00FFFF);
        step(1, 1, 1, 1, 24'hFFFFFF, "load all ones");
        step(1, 1, 1, 1, 24'hABCDEF, "load beats wrap, tc high"); // R5 R6
        step(1, 1, 1, 1, 24'h000000, "load zero");
        step(1, 1, 0, 1, 24'h555555, "load beats borrow, tc high");
        step(1, 0, 1, 0, '0, "hold while up");
        for (int i = 0; i < 4000; i++) begin
            logic [W-1:0] d;
            logic rn, c, u, l;
            rn = ($urandom % 64) != 0;
            c  = ($urandom % 4) != 0;
            u  = $urandom % 2;
            l  = ($urandom % 16) == 0;
            case ($urandom % 4)
                0: d = 24'hFFFFFF - W'($urandom % 3);
                1: d = W'($urandom % 3);
                default: d = W'($urandom);
            endcase
            step(rn, c, u, l, d, "random");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule